// File: doc/BRIEF.md
# RISC Integer ALU with Flags

This block is the arithmetic and logic unit of a small load/store integer core. It is purely combinational. Each cycle it takes two 32-bit operands and a 4-bit operation select. It returns a 32-bit result together with a zero flag and a signed-overflow flag. Any immediate operand has already been sign- or zero-extended to 32 bits before it reaches the block. Shifts, multiply and divide are handled elsewhere.

All arithmetic shares one carry chain. A subtract inverts the second operand and forces the carry-in high. Both compare operations reuse that subtraction. The signed compare corrects the sign of the difference with the overflow term. The unsigned compare reads the borrow, which is the inverted carry-out. Overflow is reported only for the two signed arithmetic codes.

The block has no states. The select value alone picks one of three datapath views, and the output stage drives from that view: the adder sum, the logic unit output, or the compare bit. Any other select value takes the null view, which gives a zero result.

Top module: `rialu_core`

## Requirements
- R1: Select codes 4'h0 (signed add) and 4'h1 (unsigned add) give result = A + B modulo 2^32.
- R2: Select codes 4'h2 (signed subtract) and 4'h3 (unsigned subtract) give result = A - B modulo 2^32.
- R3: Select codes 4'h4, 4'h5, 4'h6 and 4'h7 give the bitwise AND, OR, XOR and NOR of A and B, in that order.
- R4: Select code 4'hA gives bit 0 = 1 when A < B as two's-complement numbers, else 0. All upper result bits are 0. The answer stays correct when A - B overflows.
- R5: Select code 4'hB gives bit 0 = 1 when A < B as unsigned numbers, else 0. All upper result bits are 0.
- R6: The zero flag is 1 exactly when all 32 result bits are 0.
- R7: For codes 4'h0 and 4'h2, the overflow flag is 1 exactly when the signed result does not fit in 32 bits. This equals the carry into bit 31 XOR the carry out of bit 31.
- R8: The overflow flag is 0 for codes 4'h1, 4'h3, 4'h4 to 4'h7, 4'hA and 4'hB, whatever the operands.
- R9: Unused codes (4'h8, 4'h9, 4'hC to 4'hF) give a zero result and no overflow, so the zero flag is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 4 | Operation select code |
| opnd_a | input | 32 | First operand (A) |
| opnd_b | input | 32 | Second operand (B) |
| result | output | 32 | Operation result |
| zero_flag | output | 1 | High when result is all zeros |
| ovf_flag | output | 1 | Signed overflow of signed add/subtract |

## Verification
Operands sit on either side of the signed boundary, such as 32'h7FFFFFFF against 32'h80000000. With these operands, the signed and unsigned add, subtract and compare codes must give different answers, so the tests show whether overflow is suppressed on the right codes and whether the signed compare corrects for overflow. Pairs whose sum or difference wraps to zero exercise the zero flag through the carry chain. A mixed bit pattern tells the four logic codes apart. Random operands on every defined and unused code are compared against a behavioural model to catch carry-chain and selection faults.

// File: rtl/rialu_pkg.sv
package rialu_pkg;
    localparam int ALU_W  = 32;
    localparam int SEL_W  = 4;

    typedef enum logic [SEL_W-1:0] {
        OP_ADD  = 4'h0,
        OP_ADDU = 4'h1,
        OP_SUB  = 4'h2,
        OP_SUBU = 4'h3,
        OP_AND  = 4'h4,
        OP_OR   = 4'h5,
        OP_XOR  = 4'h6,
        OP_NOR  = 4'h7,
        OP_SLT  = 4'hA,
        OP_SLTU = 4'hB
    } alu_op_e;

    typedef enum logic [1:0] {
        VIEW_SUM,
        VIEW_LOGIC,
        VIEW_CMP,
        VIEW_NULL
    } alu_view_e;

    typedef struct packed {
        logic      sub_mode;
        logic      signed_ovf;
        logic      cmp_signed;
        logic [1:0] logic_fn;
        alu_view_e view;
    } alu_ctl_t;
endpackage

// File: rtl/rialu_decode.sv
module rialu_decode
    import rialu_pkg::*;
(
    input  logic [SEL_W-1:0] op_sel,
    output alu_ctl_t         ctl
);
    always_comb begin
        ctl = '{sub_mode: 1'b0, signed_ovf: 1'b0, cmp_signed: 1'b0,
                logic_fn: 2'd0, view: VIEW_NULL};
        case (op_sel)
            OP_ADD:  begin ctl.view = VIEW_SUM; ctl.signed_ovf = 1'b1; end
            OP_ADDU: begin ctl.view = VIEW_SUM; end
            OP_SUB:  begin ctl.view = VIEW_SUM; ctl.sub_mode = 1'b1; ctl.signed_ovf = 1'b1; end
            OP_SUBU: begin ctl.view = VIEW_SUM; ctl.sub_mode = 1'b1; end
            OP_AND:  begin ctl.view = VIEW_LOGIC; ctl.logic_fn = 2'd0; end
            OP_OR:   begin ctl.view = VIEW_LOGIC; ctl.logic_fn = 2'd1; end
            OP_XOR:  begin ctl.view = VIEW_LOGIC; ctl.logic_fn = 2'd2; end
            OP_NOR:  begin ctl.view = VIEW_LOGIC; ctl.logic_fn = 2'd3; end
            OP_SLT:  begin ctl.view = VIEW_CMP; ctl.sub_mode = 1'b1; ctl.cmp_signed = 1'b1; end
            OP_SLTU: begin ctl.view = VIEW_CMP; ctl.sub_mode = 1'b1; end
            default: ctl.view = VIEW_NULL;
        endcase
    end
endmodule

// File: rtl/rialu_addsub.sv
module rialu_addsub #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             sub_mode,
    output logic [WIDTH-1:0] sum,
    output logic             carry_msb_in,
    output logic             carry_out
);
    logic [WIDTH:0]   chain;
    logic [WIDTH-1:0] b_eff;

    assign b_eff    = b ^ {WIDTH{sub_mode}};
    assign chain[0] = sub_mode;

    for (genvar i = 0; i < WIDTH; i++) begin : g_cell
        assign sum[i]     = a[i] ^ b_eff[i] ^ chain[i];
        assign chain[i+1] = (a[i] & b_eff[i]) | (a[i] & chain[i]) | (b_eff[i] & chain[i]);
    end

    assign carry_msb_in = chain[WIDTH-1];
    assign carry_out    = chain[WIDTH];
endmodule

// File: rtl/rialu_logic.sv
module rialu_logic #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic [1:0]       fn,
    output logic [WIDTH-1:0] y
);
    always_comb begin
        case (fn)
            2'd0:    y = a & b;
            2'd1:    y = a | b;
            2'd2:    y = a ^ b;
            default: y = ~(a | b);
        endcase
    end
endmodule

// File: rtl/rialu_core.sv
module rialu_core
    import rialu_pkg::*;
#(
    parameter int WIDTH = ALU_W
) (
    input  logic [SEL_W-1:0] op_sel,
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    output logic [WIDTH-1:0] result,
    output logic             zero_flag,
    output logic             ovf_flag
);
    localparam int MSB = WIDTH - 1;

    alu_ctl_t         ctl;
    logic [WIDTH-1:0] sum;
    logic [WIDTH-1:0] logic_y;
    logic             c_msb_in;
    logic             c_out;
    logic             raw_ovf;
    logic             less_bit;

    rialu_decode u_decode (
        .op_sel (op_sel),
        .ctl    (ctl)
    );

    rialu_addsub #(.WIDTH(WIDTH)) u_addsub (
        .a            (opnd_a),
        .b            (opnd_b),
        .sub_mode     (ctl.sub_mode),
        .sum          (sum),
        .carry_msb_in (c_msb_in),
        .carry_out    (c_out)
    );

    rialu_logic #(.WIDTH(WIDTH)) u_logic (
        .a  (opnd_a),
        .b  (opnd_b),
        .fn (ctl.logic_fn),
        .y  (logic_y)
    );

    assign raw_ovf  = c_msb_in ^ c_out;
    assign less_bit = ctl.cmp_signed ? (sum[MSB] ^ raw_ovf) : ~c_out;

    always_comb begin
        result   = '0;
        ovf_flag = 1'b0;
        unique case (ctl.view)
            VIEW_SUM: begin
                result   = sum;
                ovf_flag = ctl.signed_ovf & raw_ovf;
            end
            VIEW_LOGIC: result = logic_y;
            VIEW_CMP:   result = {{(WIDTH-1){1'b0}}, less_bit};
            VIEW_NULL:  result = '0;
        endcase
    end

    assign zero_flag = (result == '0);

    always_comb begin
        if (!$isunknown({op_sel, opnd_a, opnd_b})) begin
            if (op_sel == OP_ADD || op_sel == OP_ADDU)
                p_add_sum_r1: assert (result == opnd_a + opnd_b);
            if (op_sel == OP_SUB || op_sel == OP_SUBU)
                p_sub_diff_r2: assert (result == opnd_a - opnd_b);
            if (op_sel == OP_SLT || op_sel == OP_SLTU)
                p_cmp_upper_r4: assert (result[MSB:1] == '0);
            if (op_sel == OP_SLT)
                p_slt_signed_r4: assert (result[0] == ($signed(opnd_a) < $signed(opnd_b)));
            if (op_sel == OP_SLTU)
                p_sltu_unsigned_r5: assert (result[0] == (opnd_a < opnd_b));
            if (op_sel != OP_ADD && op_sel != OP_SUB)
                p_no_overflow_r8: assert (!ovf_flag);
            if (op_sel == 4'h8 || op_sel == 4'h9 || op_sel >= 4'hC)
                p_unused_quiet_r9: assert (zero_flag && result == '0);
        end
    end
endmodule

// File: tb/rialu_core_bench.sv
module rialu_core_bench;
    localparam int W = 32;
    localparam int NV = 18;
    localparam int NRAND = 400;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [3:0]   op_sel;
    logic [W-1:0] opnd_a, opnd_b;
    logic [W-1:0] result;
    logic         zero_flag, ovf_flag;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    rialu_core u_rialu_core (
        .op_sel    (op_sel),
        .opnd_a    (opnd_a),
        .opnd_b    (opnd_b),
        .result    (result),
        .zero_flag (zero_flag),
        .ovf_flag  (ovf_flag)
    );

    // {op, a, b, expected result, expected zero, expected overflow}
    localparam logic [101:0] VEC [NV] = '{
        {4'h0, 32'h7FFFFFFF, 32'h00000001, 32'h80000000, 1'b0, 1'b1}, // R1 R7
        {4'h1, 32'h7FFFFFFF, 32'h00000001, 32'h80000000, 1'b0, 1'b0}, // R1 R8
        {4'h0, 32'hFFFFFFFF, 32'h00000001, 32'h00000000, 1'b1, 1'b0}, // R1 R6
        {4'h0, 32'h80000000, 32'h80000000, 32'h00000000, 1'b1, 1'b1}, // R7
        {4'h2, 32'h80000000, 32'h00000001, 32'h7FFFFFFF, 1'b0, 1'b1}, // R2 R7
        {4'h3, 32'h00000000, 32'h00000001, 32'hFFFFFFFF, 1'b0, 1'b0}, // R2 R8
        {4'h2, 32'h00000005, 32'h00000005, 32'h00000000, 1'b1, 1'b0}, // R2 R6
        {4'h4, 32'h000003C0, 32'h000000D0, 32'h000000C0, 1'b0, 1'b0}, // R3
        {4'h5, 32'h000003C0, 32'h000000D0, 32'h000003D0, 1'b0, 1'b0}, // R3
        {4'h6, 32'h000003C0, 32'h000000D0, 32'h00000310, 1'b0, 1'b0}, // R3
        {4'h7, 32'h000003C0, 32'h000000D0, 32'hFFFFFC2F, 1'b0, 1'b0}, // R3
        {4'hA, 32'h80000000, 32'h7FFFFFFF, 32'h00000001, 1'b0, 1'b0}, // R4
        {4'hA, 32'h7FFFFFFF, 32'h80000000, 32'h00000000, 1'b1, 1'b0}, // R4
        {4'hA, 32'hFFFFFFFF, 32'h00000000, 32'h00000001, 1'b0, 1'b0}, // R4
        {4'hB, 32'h80000000, 32'h7FFFFFFF, 32'h00000000, 1'b1, 1'b0}, // R5
        {4'hB, 32'h00000001, 32'hFFFFFFFF, 32'h00000001, 1'b0, 1'b0}, // R5
        {4'h8, 32'hFFFFFFFF, 32'h00000001, 32'h00000000, 1'b1, 1'b0}, // R9
        {4'hF, 32'h7FFFFFFF, 32'h00000001, 32'h00000000, 1'b1, 1'b0}  // R9
    };

    function automatic logic [W+1:0] ref_model(input logic [3:0] op,
                                               input logic [W-1:0] a,
                                               input logic [W-1:0] b);
        logic [W-1:0] r;
        logic v;
        logic signed [W:0] wide;
        r = '0;
        v = 1'b0;
        case (op)
            4'h0: begin
                r = a + b;
                wide = $signed({a[W-1], a}) + $signed({b[W-1], b});
                v = (wide > 33'sh0_7FFFFFFF) || (wide < -33'sh0_80000000);
            end
            4'h1: r = a + b;
            4'h2: begin
                r = a - b;
                wide = $signed({a[W-1], a}) - $signed({b[W-1], b});
                v = (wide > 33'sh0_7FFFFFFF) || (wide < -33'sh0_80000000);
            end
            4'h3: r = a - b;
            4'h4: r = a & b;
            4'h5: r = a | b;
            4'h6: r = a ^ b;
            4'h7: r = ~(a | b);
            4'hA: r = {31'd0, ($signed(a) < $signed(b))};
            4'hB: r = {31'd0, (a < b)};
            default: r = '0;
        endcase
        return {r, (r == '0), v};
    endfunction

    task automatic check(input string tag, input logic [W-1:0] er,
                         input logic ez, input logic ev);
        n_checks++;
        if (result !== er || zero_flag !== ez || ovf_flag !== ev) begin
            n_fail++;
            $display("FAIL %s op=%h a=%h b=%h: got res=%h z=%b v=%b, expected res=%h z=%b v=%b",
                     tag, op_sel, opnd_a, opnd_b, result, zero_flag, ovf_flag, er, ez, ev);
        end
    endtask

    task automatic apply(input logic [3:0] op, input logic [W-1:0] a, input logic [W-1:0] b);
        @(posedge clk);
        op_sel = op;
        opnd_a = a;
        opnd_b = b;
        @(negedge clk);
    endtask

    initial begin
        op_sel = 4'h0;
        opnd_a = '0;
        opnd_b = '0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        // idle state: zero operands on add give zero result (R1 R6)
        check("R6 idle", 32'h0, 1'b1, 1'b0);

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][101:98], VEC[i][97:66], VEC[i][65:34]);
            check("R1-R9 table", VEC[i][33:2], VEC[i][1], VEC[i][0]);
        end

        // random operands on every code; tags R1 R2 R3 R4 R5 R6 R7 R8 R9 via model
        for (int i = 0; i < NRAND; i++) begin
            logic [W+1:0] e;
            logic [3:0] op;
            logic [W-1:0] a, b;
            op = 4'($urandom_range(0, 15));
            a  = $urandom;
            b  = (i % 8 == 0) ? a : $urandom;
            apply(op, a, b);
            e = ref_model(op, a, b);
            check("R_random", e[W+1:2], e[1], e[0]);
        end

        // directed: overflow suppression on unsigned subtract of boundary values (R8)
        apply(4'h3, 32'h80000000, 32'h00000001);
        check("R8 subu", 32'h7FFFFFFF, 1'b0, 1'b0);
        // directed: signed compare equal operands gives 0 (R4)
        apply(4'hA, 32'h12345678, 32'h12345678);
        check("R4 equal", 32'h0, 1'b1, 1'b0);
        // directed: unused code 9 with operands that would overflow (R9)
        apply(4'h9, 32'h80000000, 32'h80000000);
        check("R9 code9", 32'h0, 1'b1, 1'b0);
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 100000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule